// File: doc/BRIEF.md
# Thread Start-up Rename Setup Engine

A speculative thread may only rename its instructions once its register map state exists. Before that point, the engine builds that state. A start request names a thread slot and two register sets. The produce set lists the registers the thread may write. The consume set lists the live-in registers it reads.

For every register in either set, the engine snapshots the current master mapping into the thread's private local table. For every register in the produce set, it also takes a fresh physical register from the free list. It records that register in the thread's pre-assign table. It then installs the register in the master table and flags it busy, so later threads wait on a value that is not yet produced.

The engine works only in rename-port slots that ordinary renaming leaves idle. The rename stage reports each cycle how many of the eight ports it occupies. This lets the setup of the next thread run underneath the current thread's fetch instead of stalling it. A per-thread completion flag tells the fetch side when renaming may begin. Lookup ports expose the three tables to the rename stage. A wake-up input clears the busy flag once a physical register's value arrives.

Top module: `rmap_setup_engine`

## Requirements
- R1: After reset the engine is idle (`engine_busy` low), every `setup_done` bit is clear, and master entry r maps to physical register r with its busy flag clear.
- R2: A start request is accepted only while the engine is idle. Acceptance clears `setup_done` of the requested thread, and the engine is busy from the next cycle. A start request raised while the engine is busy is ignored, and it leaves the completion flag of the thread it names unchanged.
- R3: In each busy cycle the engine performs at most max(0, 8 - `ports_used`) table operations. A register copy counts as one operation and a register commit counts as one. When `ports_used` is 8 or more, nothing advances.
- R4: Operations run in ascending architectural register number. For each register, the copy comes before the commit. The first operation that cannot proceed in a cycle ends that cycle's work, so no later operation overtakes it.
- R5: For each register r in the union of the produce and consume sets, local[tid][r] receives the master mapping of r. Local entries of registers outside both sets keep their previous values.
- R6: For each register r in the produce set, exactly one free-list entry is popped (`fl_pop` high, at most one per cycle). Its number is written to pre[tid][r] and to master[r], and the master busy flag of r is set.
- R7: While `fl_valid` is low, `fl_pop` stays low. No master entry changes, and setup waits at the first pending commit.
- R8: The local table always receives the master mapping from before this setup's own commit of that register. A later thread that copies a register produced by an earlier setup receives that setup's pre-assigned register.
- R9: `setup_done[tid]` rises, and `engine_busy` falls, on the clock edge that completes the last operation. With both sets empty, this happens on the edge at the end of the first busy cycle.
- R10: A `wake_valid` pulse clears the busy flag of every master entry that maps to `wake_preg`. A commit to the same entry in the same cycle leaves it busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Request to set up a thread |
| start_tid | input | TID_W (2) | Thread slot of the request |
| start_create | input | NUM_ARCH (16) | Produce set, one bit per architectural register |
| start_use | input | NUM_ARCH (16) | Consume set, one bit per architectural register |
| ports_used | input | CNT_W (4) | Rename ports taken by ordinary renaming this cycle |
| fl_valid | input | 1 | Free list offers a physical register |
| fl_preg | input | PREG_W (6) | Offered physical register |
| fl_pop | output | 1 | Offered register is consumed this cycle |
| wake_valid | input | 1 | A physical register value became available |
| wake_preg | input | PREG_W (6) | The register that became available |
| lk_tid | input | TID_W (2) | Lookup thread slot |
| lk_areg | input | AREG_W (4) | Lookup architectural register |
| lk_local_preg | output | PREG_W (6) | Local table entry of lk_tid / lk_areg |
| lk_pre_preg | output | PREG_W (6) | Pre-assign table entry of lk_tid / lk_areg |
| lk_master_preg | output | PREG_W (6) | Master mapping of lk_areg |
| lk_master_busy | output | 1 | Master busy flag of lk_areg |
| engine_busy | output | 1 | A setup is in progress |
| setup_done | output | NUM_THREADS (4) | Per-thread setup completion flags |

## Verification
The assertions assume the following about the inputs:
- `fl_preg` is stable while `fl_valid` is high within a cycle.
- Whoever drives `start_valid` watches `engine_busy`.
- `ports_used` is reported for the same cycle in which the engine uses the leftover slots.

The stimulus drives every input at the falling edge, so each cycle has a single settled value. It draws `ports_used` from 0 to 12 so that saturation above eight occurs. It withholds the free list at random and in directed runs of several cycles. It raises a start only while idle, apart from one deliberate mid-setup intrusion that tests R2. Wake-ups are issued only between setups.

// File: rtl/rms_pkg.sv
// Shared types of the rename setup engine.
// Assumes: nothing beyond IEEE 1800-2017.
package rms_pkg;
    typedef enum logic [0:0] {
        RMS_IDLE = 1'b0,
        RMS_BUSY = 1'b1
    } rms_state_e;
endpackage

// File: rtl/rms_op_sched.sv
// Picks this cycle's copy and commit operations.
// The candidates are visited in strict order: register 0 copy, register 0
// commit, register 1 copy, and so on. Each step takes one spare port.
// Commits also need a free-list entry, and only one commit fits per cycle.
// The first step that cannot go ends the scan.
// Assumes: cm_pend is a subset of registers whose copy is pending or done.
module rms_op_sched #(
    parameter int NUM_ARCH = 16,
    parameter int CNT_W    = 4
) (
    input  logic [NUM_ARCH-1:0] cp_pend,
    input  logic [NUM_ARCH-1:0] cm_pend,
    input  logic [CNT_W-1:0]    avail,
    input  logic                fl_valid,
    output logic [NUM_ARCH-1:0] cp_go,
    output logic [NUM_ARCH-1:0] cm_go
);
    // Ordered scan of the pending operations against the port budget.
    always_comb begin : scan_p
        int   budget;
        logic blocked;
        logic alloc_used;
        budget     = int'(avail);
        blocked    = 1'b0;
        alloc_used = 1'b0;
        cp_go      = '0;
        cm_go      = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            if (!blocked && cp_pend[i]) begin
                if (budget > 0) begin
                    cp_go[i] = 1'b1;
                    budget   = budget - 1;
                end else begin
                    blocked = 1'b1;
                end
            end
            if (!blocked && cm_pend[i]) begin
                if (budget > 0 && fl_valid && !alloc_used) begin
                    cm_go[i]   = 1'b1;
                    budget     = budget - 1;
                    alloc_used = 1'b1;
                end else begin
                    blocked = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rms_master_table.sv
// Master rename table: one mapping and one busy flag per architectural
// register. The setup commit writes a new mapping and sets busy. A wake-up
// clears busy on every entry holding the woken register.
// Assumes: NUM_PHYS >= NUM_ARCH, so the identity map exists at reset.
module rms_master_table #(
    parameter int NUM_ARCH = 16,
    parameter int PREG_W   = 6,
    parameter int AREG_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            commit_we,
    input  logic [AREG_W-1:0]               commit_areg,
    input  logic [PREG_W-1:0]               commit_preg,
    input  logic                            wake_valid,
    input  logic [PREG_W-1:0]               wake_preg,
    input  logic [AREG_W-1:0]               rd_areg,
    output logic [PREG_W-1:0]               rd_preg,
    output logic                            rd_busy,
    output logic [NUM_ARCH-1:0][PREG_W-1:0] map_all
);
    logic [NUM_ARCH-1:0][PREG_W-1:0] map_q;
    logic [NUM_ARCH-1:0]             busy_q;

    // Mapping storage: identity at reset, commit overwrites one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= PREG_W'(i);
            end
        end else if (commit_we) begin
            map_q[commit_areg] <= commit_preg;
        end
    end

    // Busy flags: a commit sets its entry, a wake-up clears matching entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                if (commit_we && commit_areg == AREG_W'(i)) begin
                    busy_q[i] <= 1'b1;
                end else if (wake_valid && map_q[i] == wake_preg) begin
                    busy_q[i] <= 1'b0;
                end
            end
        end
    end

    // Read side: the lookup port and the full vector for local-table copies.
    always_comb begin : read_p
        rd_preg = map_q[rd_areg];
        rd_busy = busy_q[rd_areg];
        map_all = map_q;
    end

    // R6: a commit leaves its register mapped to the popped entry and busy.
    p_busy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_we |=> (busy_q[$past(commit_areg)] &&
                       map_q[$past(commit_areg)] == $past(commit_preg)));

    // R10: a wake-up with no commit clears busy on the entry it matches.
    p_wake_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && !commit_we && map_q[rd_areg] == wake_preg)
            |=> !busy_q[$past(rd_areg)]);
endmodule

// File: rtl/rms_thread_tables.sv
// Per-thread local and pre-assign tables. The local table takes master
// snapshots for the registers copied this cycle. The pre-assign table takes
// the popped register at commit. Writes go only to the thread being set up.
// Assumes: at most one pre-assign write per cycle.
module rms_thread_tables #(
    parameter int NUM_ARCH    = 16,
    parameter int NUM_THREADS = 4,
    parameter int PREG_W      = 6,
    parameter int AREG_W      = 4,
    parameter int TID_W       = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [TID_W-1:0]                wr_tid,
    input  logic [NUM_ARCH-1:0]             copy_en,
    input  logic [NUM_ARCH-1:0][PREG_W-1:0] master_map,
    input  logic                            pre_we,
    input  logic [AREG_W-1:0]               pre_areg,
    input  logic [PREG_W-1:0]               pre_preg,
    input  logic [TID_W-1:0]                rd_tid,
    input  logic [AREG_W-1:0]               rd_areg,
    output logic [PREG_W-1:0]               rd_local,
    output logic [PREG_W-1:0]               rd_pre
);
    logic [NUM_THREADS-1:0][NUM_ARCH-1:0][PREG_W-1:0] local_q;
    logic [NUM_THREADS-1:0][NUM_ARCH-1:0][PREG_W-1:0] pre_q;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        // Local snapshot storage of thread t.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                local_q[t] <= '0;
            end else if (wr_tid == TID_W'(t)) begin
                for (int i = 0; i < NUM_ARCH; i++) begin
                    if (copy_en[i]) begin
                        local_q[t][i] <= master_map[i];
                    end
                end
            end
        end

        // Pre-assign storage of thread t.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[t] <= '0;
            end else if (pre_we && wr_tid == TID_W'(t)) begin
                pre_q[t][pre_areg] <= pre_preg;
            end
        end
    end

    // Lookup port used by the rename stage.
    always_comb begin : read_p
        rd_local = local_q[rd_tid][rd_areg];
        rd_pre   = pre_q[rd_tid][rd_areg];
    end

    // R8: a copy and a commit of the same register in one cycle leave the
    // local entry holding the pre-commit mapping, not the popped one.
    p_copy_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_we && copy_en[pre_areg])
            |=> local_q[$past(wr_tid)][$past(pre_areg)] ==
                $past(master_map[pre_areg]));
endmodule

// File: rtl/rmap_setup_engine.sv
// Thread start-up rename setup engine (top).
// It accepts one start request while idle and latches the two register sets.
// Each busy cycle it spends the rename ports left over by ordinary renaming
// on copies (master to local) and commits (free list to pre-assign and
// master, marked busy). It stops after the last operation and raises the
// thread's completion flag.
// Assumes: the free list offers at most one register per cycle.
module rmap_setup_engine #(
    parameter int NUM_ARCH     = 16,
    parameter int NUM_PHYS     = 64,
    parameter int NUM_THREADS  = 4,
    parameter int RENAME_PORTS = 8,
    localparam int AREG_W = $clog2(NUM_ARCH),
    localparam int PREG_W = $clog2(NUM_PHYS),
    localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W  = $clog2(RENAME_PORTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_valid,
    input  logic [TID_W-1:0]       start_tid,
    input  logic [NUM_ARCH-1:0]    start_create,
    input  logic [NUM_ARCH-1:0]    start_use,
    input  logic [CNT_W-1:0]       ports_used,
    input  logic                   fl_valid,
    input  logic [PREG_W-1:0]      fl_preg,
    output logic                   fl_pop,
    input  logic                   wake_valid,
    input  logic [PREG_W-1:0]      wake_preg,
    input  logic [TID_W-1:0]       lk_tid,
    input  logic [AREG_W-1:0]      lk_areg,
    output logic [PREG_W-1:0]      lk_local_preg,
    output logic [PREG_W-1:0]      lk_pre_preg,
    output logic [PREG_W-1:0]      lk_master_preg,
    output logic                   lk_master_busy,
    output logic                   engine_busy,
    output logic [NUM_THREADS-1:0] setup_done
);
    import rms_pkg::*;

    rms_state_e                      state_q;
    logic [TID_W-1:0]                cur_tid_q;
    logic [NUM_ARCH-1:0]             create_q;
    logic [NUM_ARCH-1:0]             use_q;
    logic [NUM_ARCH-1:0]             cp_done_q;
    logic [NUM_ARCH-1:0]             cm_done_q;
    logic [NUM_THREADS-1:0]          done_q;
    logic [NUM_ARCH-1:0]             cp_pend;
    logic [NUM_ARCH-1:0]             cm_pend;
    logic [NUM_ARCH-1:0]             cp_go;
    logic [NUM_ARCH-1:0]             cm_go;
    logic [CNT_W-1:0]                avail;
    logic [AREG_W-1:0]               commit_areg;
    logic                            busy;
    logic                            accept;
    logic                            finish;
    logic [NUM_ARCH-1:0][PREG_W-1:0] master_map;

    // Spare-port count and the outstanding work of the current setup.
    always_comb begin : pend_p
        busy    = (state_q == RMS_BUSY);
        accept  = (state_q == RMS_IDLE) && start_valid;
        avail   = (ports_used >= CNT_W'(RENAME_PORTS)) ? '0
                : CNT_W'(RENAME_PORTS) - ports_used;
        cp_pend = busy ? ((create_q | use_q) & ~cp_done_q) : '0;
        cm_pend = busy ? (create_q & ~cm_done_q) : '0;
        finish  = busy && ((cp_pend & ~cp_go) == '0) && ((cm_pend & ~cm_go) == '0);
    end

    rms_op_sched #(
        .NUM_ARCH (NUM_ARCH),
        .CNT_W    (CNT_W)
    ) u_sched (
        .cp_pend  (cp_pend),
        .cm_pend  (cm_pend),
        .avail    (avail),
        .fl_valid (fl_valid),
        .cp_go    (cp_go),
        .cm_go    (cm_go)
    );

    // Register number of this cycle's commit (at most one bit is set).
    always_comb begin : enc_p
        commit_areg = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            if (cm_go[i]) begin
                commit_areg = AREG_W'(i);
            end
        end
        fl_pop = |cm_go;
    end

    // Sequencer: accept, track per-register progress, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RMS_IDLE;
            cur_tid_q <= '0;
            create_q  <= '0;
            use_q     <= '0;
            cp_done_q <= '0;
            cm_done_q <= '0;
        end else if (accept) begin
            state_q   <= RMS_BUSY;
            cur_tid_q <= start_tid;
            create_q  <= start_create;
            use_q     <= start_use;
            cp_done_q <= '0;
            cm_done_q <= '0;
        end else if (busy) begin
            cp_done_q <= cp_done_q | cp_go;
            cm_done_q <= cm_done_q | cm_go;
            if (finish) begin
                state_q <= RMS_IDLE;
            end
        end
    end

    // Completion flags: cleared on acceptance, set on the finishing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
        end else if (accept) begin
            done_q[start_tid] <= 1'b0;
        end else if (finish) begin
            done_q[cur_tid_q] <= 1'b1;
        end
    end

    rms_master_table #(
        .NUM_ARCH (NUM_ARCH),
        .PREG_W   (PREG_W),
        .AREG_W   (AREG_W)
    ) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_we   (fl_pop),
        .commit_areg (commit_areg),
        .commit_preg (fl_preg),
        .wake_valid  (wake_valid),
        .wake_preg   (wake_preg),
        .rd_areg     (lk_areg),
        .rd_preg     (lk_master_preg),
        .rd_busy     (lk_master_busy),
        .map_all     (master_map)
    );

    rms_thread_tables #(
        .NUM_ARCH    (NUM_ARCH),
        .NUM_THREADS (NUM_THREADS),
        .PREG_W      (PREG_W),
        .AREG_W      (AREG_W),
        .TID_W       (TID_W)
    ) u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_tid     (cur_tid_q),
        .copy_en    (cp_go),
        .master_map (master_map),
        .pre_we     (fl_pop),
        .pre_areg   (commit_areg),
        .pre_preg   (fl_preg),
        .rd_tid     (lk_tid),
        .rd_areg    (lk_areg),
        .rd_local   (lk_local_preg),
        .rd_pre     (lk_pre_preg)
    );

    // Output drive.
    always_comb begin : out_p
        engine_busy = busy;
        setup_done  = done_q;
    end

    // R3: no work at all when ordinary renaming occupies every port.
    p_no_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ports_used >= CNT_W'(RENAME_PORTS)) |-> (cp_go == '0 && cm_go == '0));

    // R3: work never exceeds the spare ports.
    p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cp_go) + $countones(cm_go)) <= int'(avail));

    // R6: at most one allocation per cycle.
    p_one_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cm_go));

    // R7: nothing is popped from an empty free list.
    p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop |-> fl_valid);

    // R9: the finishing edge returns to idle and flags the thread.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!engine_busy && setup_done[$past(cur_tid_q)]));

    // R4: a commit never precedes the copy of the same register.
    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ord
        p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cm_go[i] |-> (cp_done_q[i] || cp_go[i]));
    end

    // R2: a start raised mid-setup leaves another thread's flag alone.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ign
        p_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && start_valid && start_tid == TID_W'(t) && cur_tid_q != TID_W'(t))
                |=> $stable(done_q[t]));
    end
endmodule

// File: tb/rmap_setup_engine_tb_top.sv
`timescale 1ns/1ps
module rmap_setup_engine_tb_top;
    localparam int NA = 16;
    localparam int NT = 4;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [1:0]  start_tid = '0;
    logic [15:0] start_create = '0;
    logic [15:0] start_use = '0;
    logic [3:0]  ports_used = '0;
    logic        fl_valid = 1'b0;
    logic [5:0]  fl_preg = '0;
    logic        fl_pop;
    logic        wake_valid = 1'b0;
    logic [5:0]  wake_preg = '0;
    logic [1:0]  lk_tid = '0;
    logic [3:0]  lk_areg = '0;
    logic [5:0]  lk_local_preg, lk_pre_preg, lk_master_preg;
    logic        lk_master_busy;
    logic        engine_busy;
    logic [3:0]  setup_done;

    rmap_setup_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_tid(start_tid),
        .start_create(start_create), .start_use(start_use), .ports_used(ports_used),
        .fl_valid(fl_valid), .fl_preg(fl_preg), .fl_pop(fl_pop),
        .wake_valid(wake_valid), .wake_preg(wake_preg), .lk_tid(lk_tid),
        .lk_areg(lk_areg), .lk_local_preg(lk_local_preg), .lk_pre_preg(lk_pre_preg),
        .lk_master_preg(lk_master_preg), .lk_master_busy(lk_master_busy),
        .engine_busy(engine_busy), .setup_done(setup_done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state built from the requirements.
    int m_map [NA];
    bit m_busy [NA];
    int m_local [NT][NA];
    int m_pre [NT][NA];
    bit m_done [NT];
    bit [15:0] m_cpdone, m_cmdone, m_cpg, m_cmg;
    int next_preg = 16;
    int ports_mode = 0;
    int stall_left = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected operations of one cycle (R3, R4, R6, R7).
    task automatic model_scan(input bit [15:0] cm, input bit [15:0] um,
                              input int used, input bit flv);
        int budget = (used >= NP) ? 0 : NP - used;
        bit blocked = 0;
        bit alloc = 0;
        m_cpg = '0;
        m_cmg = '0;
        for (int i = 0; i < NA; i++) begin
            if (!blocked && (cm[i] | um[i]) && !m_cpdone[i]) begin
                if (budget > 0) begin m_cpg[i] = 1; budget--; end
                else blocked = 1;
            end
            if (!blocked && cm[i] && !m_cmdone[i]) begin
                if (budget > 0 && flv && !alloc) begin
                    m_cmg[i] = 1; budget--; alloc = 1;
                end else blocked = 1;
            end
        end
    endtask

    task automatic verify_thread(input int tid, input bit [15:0] cm);
        for (int r = 0; r < NA; r++) begin
            lk_tid = 2'(tid);
            lk_areg = 4'(r);
            #1;
            chk(lk_local_preg == 6'(m_local[tid][r]), "R5/R8 local entry", lk_local_preg, m_local[tid][r]);
            if (cm[r]) chk(lk_pre_preg == 6'(m_pre[tid][r]), "R6 pre-assign entry", lk_pre_preg, m_pre[tid][r]);
            chk(lk_master_preg == 6'(m_map[r]), "R6 master map", lk_master_preg, m_map[r]);
            chk(lk_master_busy == m_busy[r], "R6/R10 master busy", lk_master_busy, m_busy[r]);
        end
    endtask

    // One complete setup; optionally raises a foreign start mid-setup (R2).
    task automatic run_setup(input int tid, input bit [15:0] cm, input bit [15:0] um,
                             input bit intrude, input int itid);
        int cyc = 0;
        bit ended = 0;
        @(negedge clk);
        start_valid = 1; start_tid = 2'(tid); start_create = cm; start_use = um;
        ports_used = 4'($urandom % 13); fl_valid = 0;
        @(posedge clk);
        m_done[tid] = 0; m_cpdone = '0; m_cmdone = '0;
        while (!ended && cyc < 200) begin
            @(negedge clk);
            chk(engine_busy == 1, "R2 busy during setup", engine_busy, 1);
            chk(setup_done[tid] == 0, "R9 not done early", setup_done[tid], 0);
            if (intrude && cyc == 0) begin
                start_valid = 1; start_tid = 2'(itid); start_create = 16'hFFFF; start_use = 16'hFFFF;
            end else begin
                start_valid = 0;
            end
            case (ports_mode)
                1: ports_used = 4'd0;
                2: ports_used = (cyc < 3) ? 4'(NP + cyc) : 4'($urandom % 13);
                default: ports_used = 4'($urandom % 13);
            endcase
            if (stall_left > 0) begin fl_valid = 0; stall_left--; end
            else fl_valid = ($urandom % 4) != 0;
            fl_preg = 6'(next_preg);
            lk_areg = 4'($urandom % NA);
            model_scan(cm, um, int'(ports_used), fl_valid);
            #2;
            chk(fl_pop == (m_cmg != 0), "R6/R7 fl_pop", fl_pop, int'(m_cmg != 0));
            chk(lk_master_preg == 6'(m_map[lk_areg]), "R7 master unchanged until commit",
                lk_master_preg, m_map[lk_areg]);
            @(posedge clk);
            for (int i = 0; i < NA; i++) if (m_cpg[i]) m_local[tid][i] = m_map[i];
            for (int i = 0; i < NA; i++) if (m_cmg[i]) begin
                m_pre[tid][i] = next_preg; m_map[i] = next_preg; m_busy[i] = 1;
                next_preg = (next_preg == 63) ? 16 : next_preg + 1;
            end
            m_cpdone |= m_cpg;
            m_cmdone |= m_cmg;
            cyc++;
            if (m_cpdone == (cm | um) && m_cmdone == cm) ended = 1;
        end
        m_done[tid] = 1;
        @(negedge clk);
        start_valid = 0; ports_used = 0; fl_valid = 0;
        #1;
        chk(engine_busy == 0, "R9 idle after last op", engine_busy, 0);
        chk(setup_done[tid] == 1, "R9 done flag", setup_done[tid], 1);
        if (intrude) chk(setup_done[itid] == m_done[itid], "R2 foreign start ignored",
                         setup_done[itid], m_done[itid]);
        verify_thread(tid, cm);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NA; r++) begin m_map[r] = r; m_busy[r] = 0; end
        for (int t = 0; t < NT; t++) begin
            m_done[t] = 0;
            for (int r = 0; r < NA; r++) begin m_local[t][r] = 0; m_pre[t][r] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        lk_areg = 4'd5;
        #1;
        chk(engine_busy == 0, "R1 idle after reset", engine_busy, 0);
        chk(setup_done == 4'd0, "R1 done flags clear", setup_done, 0);
        chk(lk_master_preg == 6'd5 && !lk_master_busy, "R1 identity map", lk_master_preg, 5);

        // R5/R6/R8: mixed sets.
        run_setup(0, 16'h0006, 16'h0031, 0, 0);
        // R8: chained thread picks up the earlier setup's registers.
        run_setup(1, 16'h0006, 16'h0002, 0, 0);
        // R4/R6: every register produced, all ports spare.
        ports_mode = 1;
        run_setup(2, 16'hFFFF, 16'hFFFF, 0, 0);
        // R9: empty sets finish after one busy cycle.
        ports_mode = 0;
        run_setup(3, 16'h0000, 16'h0000, 0, 0);
        // R3: saturated ports at the start.
        ports_mode = 2;
        run_setup(0, 16'h8001, 16'h0100, 0, 0);
        // R7: free list withheld for six cycles.
        ports_mode = 1; stall_left = 6;
        run_setup(1, 16'h0410, 16'h0000, 0, 0);
        // R2: foreign start mid-setup for a thread that is already done.
        ports_mode = 0;
        run_setup(2, 16'h00F0, 16'h0F00, 1, 3);
        // Random setups.
        for (int k = 0; k < 20; k++) begin
            run_setup(int'($urandom % NT), 16'($urandom), 16'($urandom), 0, 0);
        end
        // R10: wake the register mapped to architectural register 4.
        @(negedge clk);
        wake_valid = 1; wake_preg = 6'(m_map[4]);
        for (int r = 0; r < NA; r++) if (m_map[r] == m_map[4]) m_busy[r] = 0;
        @(negedge clk);
        wake_valid = 0; lk_areg = 4'd4;
        #1;
        chk(lk_master_busy == 0, "R10 wake clears busy", lk_master_busy, 0);
        verify_thread(0, 16'h0000);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule